// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a single write-only control register into per-CPU software interrupt requests for a cluster of up to eight CPUs. A write carries an interrupt number, an explicit list of target CPUs and a filter mode. The block resolves the filter into a set of targets. For each target it remembers, per interrupt number, which requesting CPUs asked for it. A target's interrupt stays pending until every requester recorded against it has been handed over.

Delivery works one CPU at a time. A delivery request names a CPU, and the block walks that CPU's stored (interrupt, source) pairs from lowest to highest. It offers one pair at a time and holds the offer until the consumer accepts or refuses it. An accepted pair has its source bit cleared. A refused pair stays recorded and comes back on the next pass. The pass closes with a one-cycle done pulse.

The controller has four states:
- `DS_IDLE`: waits for a delivery request and latches the CPU.
- `DS_SCAN`: looks for the next set pair at or above the cursor. It goes to `DS_OFFER` on a hit and to `DS_DONE` when nothing is left.
- `DS_OFFER`: presents the pair. On accept or refuse it advances the cursor and returns to `DS_SCAN`.
- `DS_DONE`: pulses done and returns to `DS_IDLE`.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending bit is 0 and neither `out_valid` nor `dlv_done` is asserted.
- R2: A write takes the interrupt number from bits [3:0], the target list from bits [23:16] and the filter mode from bits [25:24]. Mode 0 uses the list as given (bit n selects CPU n), and mode 0 with an empty list changes nothing.
- R3: Mode 1 targets every CPU whose number is below `online_cnt`, except the requester `req_cpu`. The list field is ignored.
- R4: Mode 2 targets only the requester `req_cpu`. The list field is ignored.
- R5: Mode 3 writes change no pending state.
- R6: For each target T, the requester's bit is set in T's source record for the interrupt. `sgi_pending[T*16+id]` is 1 exactly while that record holds at least one source, so an interrupt requested by several CPUs stays pending until all of them are delivered.
- R7: `bus_rdata` always reads 0.
- R8: After `dlv_req` in idle with CPU C, pairs are offered on `out_sgi`/`out_src` with `out_cpu`=C, in ascending order of id*8+source. Each offer is held unchanged until `out_accept` or `out_refuse`.
- R9: An accepted pair's source bit is cleared. A refused pair's bit stays set and is offered again on the next pass.
- R10: Each pass ends with `dlv_done` high for exactly one cycle, including a pass that finds nothing. A `dlv_req` raised while a pass is running is ignored.
- R11: If a write sets the same (target, interrupt, source) bit in the cycle that pair is accepted, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 32 | Write data: id, target list, filter mode |
| bus_rdata | output | 32 | Read data, always zero |
| req_cpu | input | 3 | CPU performing the write |
| online_cnt | input | 4 | Number of online CPUs (1 to 8) |
| dlv_req | input | 1 | Start a delivery pass |
| dlv_cpu | input | 3 | CPU whose records the pass walks |
| sgi_pending | output | 128 | Pending bit per CPU and interrupt, index cpu*16+id |
| out_valid | output | 1 | A pair is on offer |
| out_cpu | output | 3 | CPU of the current pass |
| out_sgi | output | 4 | Interrupt number on offer |
| out_src | output | 3 | Requesting CPU on offer |
| out_accept | input | 1 | Consumer takes the offered pair |
| out_refuse | input | 1 | Consumer declines the offered pair |
| dlv_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions assume several things about the inputs:
- `out_accept` and `out_refuse` are never raised together, and are raised only while an offer is on the ports.
- `req_cpu` names an existing CPU.
- `online_cnt` lies between 1 and the CPU count.

The stimulus keeps to this. It drives accept or refuse for a single cycle and only after it has seen `out_valid`. It keeps `online_cnt` in range, and it deliberately overlaps a write with an accept only in the one collision case that R11 defines.

// File: rtl/sgi_disp_pkg.sv
package sgi_disp_pkg;
    localparam int ID_LSB    = 0;
    localparam int ID_BITS   = 4;
    localparam int LIST_LSB  = 16;
    localparam int LIST_BITS = 8;
    localparam int MODE_LSB  = 24;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } filt_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_SCAN,
        DS_OFFER,
        DS_DONE
    } dstate_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
    import sgi_disp_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int CNT_W = CPU_W + 1
) (
    input  logic                 wr,
    input  logic [31:0]          wdata,
    input  logic [CPU_W-1:0]     req_cpu,
    input  logic [CNT_W-1:0]     online_cnt,
    output logic                 fire,
    output logic [ID_BITS-1:0]   sgi_id,
    output logic [NUM_CPUS-1:0]  targets
);
    logic [LIST_BITS-1:0] list_full;
    logic [NUM_CPUS-1:0]  online_m;
    logic [NUM_CPUS-1:0]  self_m;
    filt_e                mode;
    logic                 unused_bits;

    assign list_full   = wdata[LIST_LSB +: LIST_BITS];
    assign sgi_id      = wdata[ID_LSB +: ID_BITS];
    assign mode        = filt_e'(wdata[MODE_LSB +: 2]);
    assign self_m      = NUM_CPUS'(1) << req_cpu;
    assign unused_bits = ^{wdata[31:26], wdata[15:4], list_full};

    generate
        for (genvar i = 0; i < NUM_CPUS; i++) begin : g_online
            assign online_m[i] = (CNT_W'(i) < online_cnt);
        end
    endgenerate

    always_comb begin
        unique case (mode)
            FLT_LIST:   targets = list_full[NUM_CPUS-1:0];
            FLT_OTHERS: targets = online_m & ~self_m;
            FLT_SELF:   targets = self_m;
            FLT_RSVD:   targets = '0;
        endcase
        fire = wr && (|targets);
    end
endmodule

// File: rtl/sgi_source_store.sv
module sgi_source_store #(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGI  = 16,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SGI_W = $clog2(NUM_SGI),
    localparam int ROW_N = NUM_SGI * NUM_CPUS,
    localparam int ALL_N = NUM_CPUS * ROW_N
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [NUM_CPUS-1:0]         set_tgt,
    input  logic [SGI_W-1:0]            set_sgi,
    input  logic [CPU_W-1:0]            set_src,
    input  logic                        clr_en,
    input  logic [CPU_W-1:0]            clr_cpu,
    input  logic [SGI_W-1:0]            clr_sgi,
    input  logic [CPU_W-1:0]            clr_src,
    input  logic [CPU_W-1:0]            row_cpu,
    output logic [ROW_N-1:0]            row,
    output logic [NUM_CPUS*NUM_SGI-1:0] pend,
    output logic [ALL_N-1:0]            mask_flat
);
    logic [NUM_CPUS-1:0] mask_q [NUM_CPUS][NUM_SGI];
    logic [NUM_CPUS-1:0] set_m  [NUM_CPUS][NUM_SGI];
    logic [NUM_CPUS-1:0] clr_m  [NUM_CPUS][NUM_SGI];
    logic [NUM_CPUS-1:0] set_oh;
    logic [NUM_CPUS-1:0] clr_oh;

    assign set_oh = NUM_CPUS'(1) << set_src;
    assign clr_oh = NUM_CPUS'(1) << clr_src;

    always_comb begin
        for (int t = 0; t < NUM_CPUS; t++) begin
            for (int s = 0; s < NUM_SGI; s++) begin
                set_m[t][s] = (set_en && set_tgt[t] && (set_sgi == SGI_W'(s)))
                              ? set_oh : '0;
                clr_m[t][s] = (clr_en && (clr_cpu == CPU_W'(t)) && (clr_sgi == SGI_W'(s)))
                              ? clr_oh : '0;
            end
        end
    end

    // A set in the same cycle as a clear wins (new request after delivery).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_CPUS; t++)
                for (int s = 0; s < NUM_SGI; s++)
                    mask_q[t][s] <= '0;
        end else begin
            for (int t = 0; t < NUM_CPUS; t++)
                for (int s = 0; s < NUM_SGI; s++)
                    mask_q[t][s] <= (mask_q[t][s] & ~clr_m[t][s]) | set_m[t][s];
        end
    end

    generate
        for (genvar t = 0; t < NUM_CPUS; t++) begin : g_cpu
            for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
                assign pend[t*NUM_SGI+s] = |mask_q[t][s];
                assign mask_flat[(t*NUM_SGI+s)*NUM_CPUS +: NUM_CPUS] = mask_q[t][s];
            end
        end
        for (genvar s = 0; s < NUM_SGI; s++) begin : g_row
            assign row[s*NUM_CPUS +: NUM_CPUS] = mask_q[row_cpu][s];
        end
    endgenerate
endmodule

// File: rtl/sgi_deliver_fsm.sv
module sgi_deliver_fsm
    import sgi_disp_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGI  = 16,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SGI_W = $clog2(NUM_SGI),
    localparam int ROW_N = NUM_SGI * NUM_CPUS,
    localparam int IDX_W = $clog2(ROW_N),
    localparam int CUR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dlv_req,
    input  logic [CPU_W-1:0] dlv_cpu,
    input  logic [ROW_N-1:0] row,
    input  logic             accept,
    input  logic             refuse,
    output logic [CPU_W-1:0] cpu_sel,
    output logic             offer_valid,
    output logic [SGI_W-1:0] offer_sgi,
    output logic [CPU_W-1:0] offer_src,
    output logic             clr_en,
    output logic             done
);
    dstate_e          state_q, state_d;
    logic [CPU_W-1:0] cpu_q, cpu_d;
    logic [CUR_W-1:0] cursor_q, cursor_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    // Lowest set pair at or above the cursor.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ROW_N - 1; i >= 0; i--) begin
            if (row[i] && (CUR_W'(i) >= cursor_q)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        cpu_d    = cpu_q;
        cursor_d = cursor_q;
        cur_d    = cur_q;
        unique case (state_q)
            DS_IDLE: begin
                if (dlv_req) begin
                    state_d  = DS_SCAN;
                    cpu_d    = dlv_cpu;
                    cursor_d = '0;
                end
            end
            DS_SCAN: begin
                if (hit) begin
                    state_d = DS_OFFER;
                    cur_d   = hit_idx;
                end else begin
                    state_d = DS_DONE;
                end
            end
            DS_OFFER: begin
                if (accept || refuse) begin
                    state_d  = DS_SCAN;
                    cursor_d = CUR_W'(cur_q) + CUR_W'(1);
                end
            end
            DS_DONE: state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= DS_IDLE;
            cpu_q    <= '0;
            cursor_q <= '0;
            cur_q    <= '0;
        end else begin
            state_q  <= state_d;
            cpu_q    <= cpu_d;
            cursor_q <= cursor_d;
            cur_q    <= cur_d;
        end
    end

    always_comb begin
        cpu_sel     = cpu_q;
        offer_valid = (state_q == DS_OFFER);
        offer_sgi   = cur_q[IDX_W-1:CPU_W];
        offer_src   = cur_q[CPU_W-1:0];
        clr_en      = (state_q == DS_OFFER) && accept;
        done        = (state_q == DS_DONE);
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_disp_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGI  = 16,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SGI_W = $clog2(NUM_SGI),
    localparam int ROW_N = NUM_SGI * NUM_CPUS,
    localparam int ALL_N = NUM_CPUS * ROW_N
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [CPU_W-1:0]            req_cpu,
    input  logic [CPU_W:0]              online_cnt,
    input  logic                        dlv_req,
    input  logic [CPU_W-1:0]            dlv_cpu,
    output logic [NUM_CPUS*NUM_SGI-1:0] sgi_pending,
    output logic                        out_valid,
    output logic [CPU_W-1:0]            out_cpu,
    output logic [SGI_W-1:0]            out_sgi,
    output logic [CPU_W-1:0]            out_src,
    input  logic                        out_accept,
    input  logic                        out_refuse,
    output logic                        dlv_done
);
    logic                fire;
    logic [ID_BITS-1:0]  dec_id;
    logic [NUM_CPUS-1:0] dec_tgt;
    logic                clr_en;
    logic [ROW_N-1:0]    row;
    logic [ALL_N-1:0]    src_mask;
    logic [CPU_W-1:0]    cpu_sel;

    assign bus_rdata = '0;

    sgi_target_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .req_cpu    (req_cpu),
        .online_cnt (online_cnt),
        .fire       (fire),
        .sgi_id     (dec_id),
        .targets    (dec_tgt)
    );

    sgi_source_store #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (fire),
        .set_tgt   (dec_tgt),
        .set_sgi   (SGI_W'(dec_id)),
        .set_src   (req_cpu),
        .clr_en    (clr_en),
        .clr_cpu   (cpu_sel),
        .clr_sgi   (out_sgi),
        .clr_src   (out_src),
        .row_cpu   (cpu_sel),
        .row       (row),
        .pend      (sgi_pending),
        .mask_flat (src_mask)
    );

    sgi_deliver_fsm #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dlv_req     (dlv_req),
        .dlv_cpu     (dlv_cpu),
        .row         (row),
        .accept      (out_accept),
        .refuse      (out_refuse),
        .cpu_sel     (cpu_sel),
        .offer_valid (out_valid),
        .offer_sgi   (out_sgi),
        .offer_src   (out_src),
        .clr_en      (clr_en),
        .done        (dlv_done)
    );

    assign out_cpu = cpu_sel;
endmodule

// File: rtl/sgi_disp_checker.sv
module sgi_disp_checker #(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGI  = 16,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SGI_W = $clog2(NUM_SGI),
    localparam int ALL_N = NUM_CPUS * NUM_SGI * NUM_CPUS
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [31:0]                 bus_wdata,
    input logic [CPU_W-1:0]            req_cpu,
    input logic [NUM_CPUS*NUM_SGI-1:0] sgi_pending,
    input logic                        out_valid,
    input logic [CPU_W-1:0]            out_cpu,
    input logic [SGI_W-1:0]            out_sgi,
    input logic [CPU_W-1:0]            out_src,
    input logic                        out_accept,
    input logic                        out_refuse,
    input logic                        dlv_done,
    input logic [ALL_N-1:0]            src_mask
);
    int unsigned pair_idx;
    int unsigned self_idx;
    logic        coll_hit;

    assign pair_idx = (int'(out_cpu) * NUM_SGI + int'(out_sgi)) * NUM_CPUS + int'(out_src);
    assign self_idx = int'(req_cpu) * NUM_SGI + int'(bus_wdata[3:0]);
    assign coll_hit = bus_wr && (bus_wdata[25:24] == 2'd0) && bus_wdata[16 + int'(out_cpu)]
                      && (bus_wdata[3:0] == 4'(out_sgi)) && (req_cpu == out_src);

    p_offer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_accept && !out_refuse |=>
        out_valid && $stable(out_sgi) && $stable(out_src) && $stable(out_cpu));

    p_offer_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sgi_pending[int'(out_cpu) * NUM_SGI + int'(out_sgi)]);

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_accept && !bus_wr |=> !src_mask[$past(pair_idx)]);

    p_refuse_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_refuse && !out_accept |=> src_mask[$past(pair_idx)]);

    p_reserved_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_wdata[25:24] == 2'd3) && !(out_valid && out_accept) |=>
        $stable(sgi_pending));

    p_self_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_wdata[25:24] == 2'd2) |=> sgi_pending[$past(self_idx)]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_done |=> !dlv_done);

    p_done_no_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dlv_done && out_valid));

    p_collide_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_accept && coll_hit |=> src_mask[$past(pair_idx)]);
endmodule

bind sgi_dispatch sgi_disp_checker #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .req_cpu     (req_cpu),
    .sgi_pending (sgi_pending),
    .out_valid   (out_valid),
    .out_cpu     (out_cpu),
    .out_sgi     (out_sgi),
    .out_src     (out_src),
    .out_accept  (out_accept),
    .out_refuse  (out_refuse),
    .dlv_done    (dlv_done),
    .src_mask    (src_mask)
);

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [2:0]   req_cpu = '0;
    logic [3:0]   online_cnt = 4'd8;
    logic         dlv_req = 1'b0;
    logic [2:0]   dlv_cpu = '0;
    logic [127:0] sgi_pending;
    logic         out_valid;
    logic [2:0]   out_cpu;
    logic [3:0]   out_sgi;
    logic [2:0]   out_src;
    logic         out_accept = 1'b0;
    logic         out_refuse = 1'b0;
    logic         dlv_done;

    int checks = 0;
    int fails  = 0;
    int got_n;
    int got_idx [32];
    int bad_cpu;
    bit done_seen;

    always #10 clk = ~clk;

    sgi_dispatch dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .req_cpu(req_cpu), .online_cnt(online_cnt),
        .dlv_req(dlv_req), .dlv_cpu(dlv_cpu), .sgi_pending(sgi_pending),
        .out_valid(out_valid), .out_cpu(out_cpu), .out_sgi(out_sgi),
        .out_src(out_src), .out_accept(out_accept), .out_refuse(out_refuse),
        .dlv_done(dlv_done)
    );

    typedef struct packed {
        logic [31:0] wd;
        logic [2:0]  src;
        logic [3:0]  onl;
        logic [7:0]  exp_tgt;
    } vec_t;

    localparam vec_t VT [9] = '{
        '{32'h0005_0003, 3'd1, 4'd8, 8'h05},  // R2 list as given
        '{32'h0000_0003, 3'd1, 4'd8, 8'h00},  // R2 empty list
        '{32'h0101_0007, 3'd2, 4'd8, 8'hFB},  // R3 all others
        '{32'h0100_0007, 3'd0, 4'd3, 8'h06},  // R3 three online
        '{32'h01FF_0002, 3'd0, 4'd1, 8'h00},  // R3 alone online
        '{32'h0203_000F, 3'd5, 4'd8, 8'h20},  // R4 self only
        '{32'h03FF_0004, 3'd2, 4'd8, 8'h00},  // R5 reserved
        '{32'h0080_FFF0, 3'd7, 4'd8, 8'h80},  // R2 junk in unused bits
        '{32'h0100_0009, 3'd7, 4'd8, 8'h7F}   // R3 requester highest
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] wd, input logic [2:0] src,
                            input logic [3:0] onl);
        bus_wr = 1'b1; bus_wdata = wd; req_cpu = src; online_cnt = onl;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_pass(input int cpu, input logic [127:0] refuse_m, input bit poke,
                            input int coll_idx, input logic [31:0] coll_wd,
                            input logic [2:0] coll_src);
        got_n = 0; bad_cpu = 0; done_seen = 0;
        dlv_req = 1'b1; dlv_cpu = 3'(cpu);
        @(negedge clk);
        dlv_req = 1'b0;
        for (int k = 0; k < 600; k++) begin
            if (dlv_done) begin
                done_seen = 1;
                break;
            end
            if (out_valid) begin
                int idx;
                idx = int'(out_sgi) * 8 + int'(out_src);
                if (int'(out_cpu) != cpu) bad_cpu++;
                if (got_n < 32) got_idx[got_n] = idx;
                got_n++;
                out_accept = !refuse_m[idx];
                out_refuse = refuse_m[idx];
                if (poke && got_n == 1) begin
                    dlv_req = 1'b1; dlv_cpu = 3'(cpu ^ 1);
                end
                if (idx == coll_idx) begin
                    bus_wr = 1'b1; bus_wdata = coll_wd; req_cpu = coll_src;
                end
                @(negedge clk);
                out_accept = 1'b0; out_refuse = 1'b0; dlv_req = 1'b0; bus_wr = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] exp;
        logic [127:0] ref_m;
        @(negedge clk);
        // R1 reset state
        chk(sgi_pending == '0, "R1 pending", sgi_pending, 0);
        chk(!out_valid && !dlv_done, "R1 outputs", {out_valid, dlv_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: decode and record
        for (int v = 0; v < 9; v++) begin
            do_reset();
            do_write(VT[v].wd, VT[v].src, VT[v].onl);
            exp = '0;
            for (int t = 0; t < 8; t++)
                if (VT[v].exp_tgt[t]) exp[t*16 + int'(VT[v].wd[3:0])] = 1'b1;
            chk(sgi_pending == exp, "R2/R3/R4/R5/R6 vector", sgi_pending, exp);
            chk(bus_rdata == '0, "R7 read zero", bus_rdata, 0);
        end

        // R6 R8 R9: several sources, order, refuse then retry
        do_reset();
        do_write(32'h0002_0004, 3'd0, 4'd8);
        do_write(32'h0002_0004, 3'd2, 4'd8);
        do_write(32'h0002_0004, 3'd6, 4'd8);
        do_write(32'h0002_0002, 3'd5, 4'd8);
        ref_m = '0; ref_m[32] = 1'b1;
        run_pass(1, ref_m, 0, -1, 0, 0);
        chk(got_n == 4, "R8 offer count", got_n, 4);
        chk(got_idx[0] == 21 && got_idx[1] == 32 && got_idx[2] == 34 && got_idx[3] == 38,
            "R8 order", {got_idx[0], got_idx[1], got_idx[2], got_idx[3]}, {32'd21, 32'd32, 32'd34, 32'd38});
        chk(bad_cpu == 0, "R8 out_cpu", bad_cpu, 0);
        chk(done_seen, "R10 done pulse", done_seen, 1);
        chk(sgi_pending[18] == 1'b0, "R9 accepted cleared", sgi_pending[18], 0);
        chk(sgi_pending[20] == 1'b1, "R6 still pending with refused source", sgi_pending[20], 1);
        run_pass(1, '0, 0, -1, 0, 0);
        chk(got_n == 1 && got_idx[0] == 32, "R9 refused reoffered", {got_n, got_idx[0]}, {32'd1, 32'd32});
        chk(sgi_pending == '0, "R6 all delivered", sgi_pending, 0);

        // R11 collision of write with accept
        do_reset();
        do_write(32'h0002_0004, 3'd0, 4'd8);
        run_pass(1, '0, 0, 32, 32'h0002_0004, 3'd0);
        chk(sgi_pending[20] == 1'b1, "R11 set wins", sgi_pending[20], 1);
        run_pass(1, '0, 0, -1, 0, 0);
        chk(got_n == 1 && sgi_pending == '0, "R11 later delivery", sgi_pending, 0);

        // R10 request while busy is ignored
        do_reset();
        do_write(32'h0200_0001, 3'd3, 4'd8);
        do_write(32'h0004_0005, 3'd0, 4'd8);
        run_pass(3, '0, 1, -1, 0, 0);
        chk(got_n == 1 && got_idx[0] == 11, "R10 busy pass offers", {got_n, got_idx[0]}, {32'd1, 32'd11});
        chk(bad_cpu == 0, "R10 out_cpu unchanged", bad_cpu, 0);
        chk(sgi_pending[37] == 1'b1, "R10 other cpu untouched", sgi_pending[37], 1);

        // R10 empty pass
        run_pass(4, '0, 0, -1, 0, 0);
        chk(got_n == 0 && done_seen, "R10 empty pass", {got_n, done_seen}, 1);
        chk(bus_rdata == '0, "R7 read zero end", bus_rdata, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule